// File: doc/BRIEF.md
# Range-Based Memory Access Rights Checker

This block decides whether a load, store or instruction fetch may touch the bytes it names. It runs alongside a virtually addressed first-level cache lookup and returns its verdict after the same fixed number of cycles as that lookup, so the pipeline can drop or keep the cache result without waiting. It accepts one new request every cycle. Address translation, refilling the table from memory and the cache itself are outside the block.

Rights are held in two tiers, and both describe byte ranges rather than pages. The first tier is three dedicated window registers: one for code, one for the stack and one for global data, heap included. They are tried first. Only when none of them fully contains an access does the block consult the second tier. That tier is a small table of general range entries used for shared mappings, older stack segments and call-gate vectors. A dedicated input pulls the stack window's upper bound down on function return, so the frame that was just left becomes unreachable.

Top module: `span_guard`

## Requirements
- R1: After reset every window and table entry is empty (base 0, bound 0, no rights) and `rsp_valid` is low, so every later access faults until something is configured.
- R2: A request presented with `req_valid` high in cycle c yields exactly one response with `rsp_valid` high in cycle c+LAT. Requests may arrive back to back. An idle cycle yields no response.
- R3: An access covers the bytes from `req_addr` up to `req_addr + 2^req_size`, with the end excluded. A window or entry with base B and exclusive bound E contains it only when `req_addr >= B` and the access end is `<= E`. The end is computed one bit wider than the address, so an access running past the top of the address space is never contained by an entry whose bound lies inside the space.
- R4: Slots 0, 1 and 2 are the code, stack and global windows. When at least one of them contains an access and one containing window holds the needed right, the response grants with `rsp_fixed` high.
- R5: When some fixed window contains an access but no containing fixed window holds the needed right, the response faults with `rsp_fixed` high, whatever the table holds.
- R6: When no fixed window contains the access, the access is granted if any table entry contains it and holds the needed right, even when other matching entries lack that right. `rsp_fixed` is then low.
- R7: When no fixed window and no permitting table entry contains the access, `rsp_fault` is high and `rsp_grant` is low. On a valid response exactly one of the two is high.
- R8: The access kind and rights are encoded as follows. Kind 0 is a read and needs rights bit 0. Kind 1 is a write and needs bit 1. Kind 2 is an execute and needs bit 2. Kind 3 never matches any right and always faults.
- R9: A configuration write loads base, bound and rights into slot `cfg_sel`. Slots 3 to 3+N_ENT-1 are table entries. A slot number beyond the last slot is ignored. A write affects requests presented in later cycles, not a request in the same cycle.
- R10: A stack cutback with a bound lower than the current stack bound replaces it. A cutback bound equal to or above the current bound is ignored.
- R11: When a configuration write to the stack slot and a cutback occur in the same cycle, the configuration write decides the stack window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W | First byte of the access |
| req_size | input | SIZE_W | Log2 of the access length in bytes |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 invalid |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Slot to write (0 code, 1 stack, 2 global, 3 and up table) |
| cfg_base | input | ADDR_W | New inclusive base |
| cfg_bound | input | ADDR_W+1 | New exclusive bound |
| cfg_perm | input | 3 | New rights {execute, write, read} |
| cut_en | input | 1 | Stack cutback strobe |
| cut_bound | input | ADDR_W+1 | Proposed new stack bound |
| rsp_valid | output | 1 | Response for the request made LAT cycles earlier |
| rsp_grant | output | 1 | Access permitted |
| rsp_fault | output | 1 | Protection fault |
| rsp_fixed | output | 1 | Decision came from a fixed window |

## Verification
The assertions take the inputs to be known values after reset. They also treat a cutback and a configuration write in the same cycle as legal, and they allow `cfg_sel` to hold an unused slot number. They do not assume that base is below bound. The bench drives every input on the falling edge from a single stimulus task, so no input is ever unknown. It sweeps every address of an 8-bit space with every size and kind, over several window layouts: overlapping table entries, a table entry that overlaps a fixed window, and a stack bound before and after cutbacks. Its expectations come from an arithmetic containment model over its own copy of the written settings.

// File: rtl/span_guard_pkg.sv
package span_guard_pkg;

  localparam int NUM_FIXED   = 3;
  localparam int PERM_W      = 3;
  localparam int SLOT_CODE   = 0;
  localparam int SLOT_STACK  = 1;
  localparam int SLOT_GLOBAL = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  // rights vector layout: bit 0 read, bit 1 write, bit 2 execute
  function automatic logic [PERM_W-1:0] need_bits(input logic [1:0] kind);
    case (acc_kind_e'(kind))
      ACC_READ:  need_bits = 3'b001;
      ACC_WRITE: need_bits = 3'b010;
      ACC_EXEC:  need_bits = 3'b100;
      default:   need_bits = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/sg_window.sv
module sg_window
  import span_guard_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W:0]       acc_lo,
  input  logic [ADDR_W:0]       acc_hi,
  input  logic [ADDR_W-1:0]     base,
  input  logic [ADDR_W:0]       bound,
  input  logic [PERM_W-1:0]     perm,
  input  logic [PERM_W-1:0]     need,
  output logic                  covers,
  output logic                  allow
);

  // Containment of the whole byte span, end exclusive, one bit wider than
  // the address so a span running off the top never wraps into a window.
  always_comb begin
    covers = (acc_lo >= {1'b0, base}) && (acc_hi <= bound);
    allow  = covers && (|(perm & need));
  end

endmodule

// File: rtl/sg_regs.sv
module sg_regs
  import span_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_SLOT = 11,
  parameter int SEL_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [SEL_W-1:0]                  cfg_sel,
  input  logic [ADDR_W-1:0]                 cfg_base,
  input  logic [ADDR_W:0]                   cfg_bound,
  input  logic [PERM_W-1:0]                 cfg_perm,
  input  logic                              cut_en,
  input  logic [ADDR_W:0]                   cut_bound,
  output logic [N_SLOT-1:0][ADDR_W-1:0]     base_o,
  output logic [N_SLOT-1:0][ADDR_W:0]       bound_o,
  output logic [N_SLOT-1:0][PERM_W-1:0]     perm_o
);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W:0]   bound_q;
    logic [PERM_W-1:0] perm_q;
    logic              hit;

    assign hit = cfg_we && (cfg_sel == SEL_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        perm_q <= '0;
      end else if (hit) begin
        base_q <= cfg_base;
        perm_q <= cfg_perm;
      end
    end

    if (s == SLOT_STACK) begin : g_stack
      // stack bound: a write wins, otherwise a cutback may only lower it
      always_ff @(posedge clk) begin
        if (rst)
          bound_q <= '0;
        else if (hit)
          bound_q <= cfg_bound;
        else if (cut_en && (cut_bound < bound_q))
          bound_q <= cut_bound;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          bound_q <= '0;
        else if (hit)
          bound_q <= cfg_bound;
      end
    end

    assign base_o[s]  = base_q;
    assign bound_o[s] = bound_q;
    assign perm_o[s]  = perm_q;
  end

  logic stack_wr;
  assign stack_wr = cfg_we && (cfg_sel == SEL_W'(SLOT_STACK));

  // R10
  cut_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (cut_en && !stack_wr && (cut_bound < bound_o[SLOT_STACK]))
      |=> (bound_o[SLOT_STACK] == $past(cut_bound)));

  // R10
  cut_never_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (cut_en && !stack_wr && (cut_bound >= bound_o[SLOT_STACK]))
      |=> $stable(bound_o[SLOT_STACK]));

  // R11
  write_beats_cut_chk: assert property (@(posedge clk) disable iff (rst)
    stack_wr |=> (bound_o[SLOT_STACK] == $past(cfg_bound)));

  // R9
  stray_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (int'(cfg_sel) >= N_SLOT) && !cut_en)
      |=> ($stable(base_o) && $stable(bound_o) && $stable(perm_o)));

endmodule

// File: rtl/sg_delay.sv
module sg_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [DEPTH-1:0][W-1:0] pipe;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];

endmodule

// File: rtl/span_guard.sv
module span_guard
  import span_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 2,
  parameter int N_ENT  = 8,
  parameter int LAT    = 2,
  localparam int NSLOT = NUM_FIXED + N_ENT,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [1:0]         req_kind,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [ADDR_W:0]    cfg_bound,
  input  logic [PERM_W-1:0]  cfg_perm,
  input  logic               cut_en,
  input  logic [ADDR_W:0]    cut_bound,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic               rsp_fault,
  output logic               rsp_fixed
);

  localparam int CW    = $clog2(LAT + 1);
  localparam int DLY_W = 5;

  initial begin
    lat_min_chk: assert (LAT >= 2);
  end

  // ---------------- settings ----------------
  logic [NSLOT-1:0][ADDR_W-1:0] rg_base;
  logic [NSLOT-1:0][ADDR_W:0]   rg_bound;
  logic [NSLOT-1:0][PERM_W-1:0] rg_perm;

  sg_regs #(
    .ADDR_W (ADDR_W),
    .N_SLOT (NSLOT),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_base  (cfg_base),
    .cfg_bound (cfg_bound),
    .cfg_perm  (cfg_perm),
    .cut_en    (cut_en),
    .cut_bound (cut_bound),
    .base_o    (rg_base),
    .bound_o   (rg_bound),
    .perm_o    (rg_perm)
  );

  // ---------------- compare stage ----------------
  logic [ADDR_W:0]   acc_lo;
  logic [ADDR_W:0]   acc_hi;
  logic [PERM_W-1:0] need;
  logic [NSLOT-1:0]  cov;
  logic [NSLOT-1:0]  alw;

  always_comb begin
    acc_lo = {1'b0, req_addr};
    acc_hi = acc_lo + ((ADDR_W+1)'(1) << req_size);
    need   = need_bits(req_kind);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_win
    sg_window #(.ADDR_W(ADDR_W)) u_win (
      .acc_lo (acc_lo),
      .acc_hi (acc_hi),
      .base   (rg_base[s]),
      .bound  (rg_bound[s]),
      .perm   (rg_perm[s]),
      .need   (need),
      .covers (cov[s]),
      .allow  (alw[s])
    );
  end

  logic fix_cov, fix_ok, tbl_cov, tbl_ok;
  always_comb begin
    fix_cov = |cov[NUM_FIXED-1:0];
    fix_ok  = |alw[NUM_FIXED-1:0];
    tbl_cov = |cov[NSLOT-1:NUM_FIXED];
    tbl_ok  = |alw[NSLOT-1:NUM_FIXED];
  end

  // ---------------- decision stage ----------------
  logic s1_valid, s1_fcov, s1_fok, s1_tcov, s1_tok;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_fcov  <= 1'b0;
      s1_fok   <= 1'b0;
      s1_tcov  <= 1'b0;
      s1_tok   <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      s1_fcov  <= req_valid && fix_cov;
      s1_fok   <= req_valid && fix_ok;
      s1_tcov  <= req_valid && tbl_cov;
      s1_tok   <= req_valid && tbl_ok;
    end
  end

  logic dec_grant, dec_fault, dec_fixed;
  always_comb begin
    dec_grant = s1_valid && (s1_fcov ? s1_fok : s1_tok);
    dec_fault = s1_valid && !dec_grant;
    dec_fixed = s1_valid && s1_fcov;
  end

  // ---------------- latency match ----------------
  logic [DLY_W-1:0] dly_q;
  logic             out_tcov;

  sg_delay #(.W(DLY_W), .DEPTH(LAT-1)) u_dly (
    .clk (clk),
    .rst (rst),
    .d   ({s1_valid, dec_grant, dec_fault, dec_fixed, s1_tcov}),
    .q   (dly_q)
  );

  assign {rsp_valid, rsp_grant, rsp_fault, rsp_fixed, out_tcov} = dly_q;

  // ---------------- checks ----------------
  logic [CW-1:0] idle_cnt;
  logic [CW-1:0] req_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      req_age  <= CW'(LAT);
    end else begin
      if (req_valid)                  idle_cnt <= '0;
      else if (idle_cnt != CW'(LAT))  idle_cnt <= idle_cnt + 1'b1;
      if (req_valid)                  req_age  <= '0;
      else if (req_age != CW'(LAT))   req_age  <= req_age + 1'b1;
    end
  end

  // R2
  no_phantom_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt == CW'(LAT)) |-> !rsp_valid);

  // R2
  rsp_on_time_chk: assert property (@(posedge clk) disable iff (rst)
    (req_age == CW'(LAT-1)) |-> rsp_valid);

  // R7
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_grant, rsp_fault}));

  // R7
  nothing_covers_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fixed && !out_tcov) |-> rsp_fault);

  // R4
  fixed_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_fixed || rsp_grant || rsp_fault) |-> rsp_valid);

endmodule

// File: tb/span_guard_test.sv
module span_guard_test;

  localparam int AW = 8;
  localparam int SZW = 2;
  localparam int NE = 4;
  localparam int LT = 2;
  localparam int NS = 3 + NE;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SZW-1:0] req_size = '0;
  logic [1:0] req_kind = '0;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0] cfg_bound = '0;
  logic [2:0] cfg_perm = '0;
  logic cut_en = 1'b0;
  logic [AW:0] cut_bound = '0;
  logic rsp_valid, rsp_grant, rsp_fault, rsp_fixed;

  always #2 clk = ~clk;

  span_guard #(.ADDR_W(AW), .SIZE_W(SZW), .N_ENT(NE), .LAT(LT)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
    .cfg_perm(cfg_perm), .cut_en(cut_en), .cut_bound(cut_bound),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_fixed(rsp_fixed)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "";

  int m_base[NS];
  int m_bound[NS];
  int m_perm[NS];

  bit    h_v[LT];
  bit    h_g[LT];
  bit    h_f[LT];
  string h_t[LT];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int a, input int sz, input int k,
                                output bit g, output bit fx, output string tag);
    int lo, hi, need;
    bit fok, tok;
    lo = a;
    hi = a + (1 << sz);
    need = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : 0;
    fx = 0; fok = 0; tok = 0;
    for (int i = 0; i < 3; i++)
      if (lo >= m_base[i] && hi <= m_bound[i]) begin
        fx = 1;
        if ((m_perm[i] & need) != 0) fok = 1;
      end
    for (int i = 3; i < NS; i++)
      if (lo >= m_base[i] && hi <= m_bound[i] && (m_perm[i] & need) != 0) tok = 1;
    g = fx ? fok : tok;
    if (phase != "")          tag = phase;
    else if (k == 3)          tag = "R8";
    else if (fx)              tag = g ? "R4" : "R5";
    else if (g)               tag = "R6";
    else if (hi > (1 << AW))  tag = "R3";
    else                      tag = "R7";
  endfunction

  // one cycle: check the response due now, then present the next request
  task automatic step(input bit v, input int a, input int sz, input int k);
    bit eg, ef;
    string t;
    if (h_v[LT-1]) begin
      check(rsp_valid === 1'b1, "R2", "valid", int'(rsp_valid), 1);
      check(rsp_grant === h_g[LT-1], h_t[LT-1], "grant", int'(rsp_grant), int'(h_g[LT-1]));
      check(rsp_fault === !h_g[LT-1], "R7", "fault", int'(rsp_fault), int'(!h_g[LT-1]));
      check(rsp_fixed === h_f[LT-1], h_t[LT-1], "fixed", int'(rsp_fixed), int'(h_f[LT-1]));
    end else begin
      check(rsp_valid === 1'b0, "R2", "idle valid", int'(rsp_valid), 0);
    end
    for (int i = LT-1; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_g[i] = h_g[i-1]; h_f[i] = h_f[i-1]; h_t[i] = h_t[i-1];
    end
    eg = 0; ef = 0; t = "R2";
    if (v) model(a, sz, k, eg, ef, t);
    h_v[0] = v; h_g[0] = eg; h_f[0] = ef; h_t[0] = t;
    req_valid = v;
    req_addr  = AW'(a);
    req_size  = SZW'(sz);
    req_kind  = 2'(k);
    @(negedge clk);
  endtask

  task automatic setup(input bit we, input int sel, input int b, input int bd, input int p,
                       input bit cut, input int cb);
    cfg_we = we; cfg_sel = SW'(sel); cfg_base = AW'(b); cfg_bound = (AW+1)'(bd);
    cfg_perm = 3'(p); cut_en = cut; cut_bound = (AW+1)'(cb);
    step(0, 0, 0, 0);
    cfg_we = 0; cut_en = 0;
    if (we && sel < NS) begin
      m_base[sel] = b; m_bound[sel] = bd; m_perm[sel] = p;
    end
    if (cut && !(we && sel == 1) && cb < m_bound[1]) m_bound[1] = cb;
  endtask

  task automatic sweep();
    for (int a = 0; a < (1 << AW); a++)
      for (int sz = 0; sz < 4; sz++)
        for (int k = 0; k < 4; k++) begin
          step(1, a, sz, k);
          if ((a + sz + k) % 11 == 0) step(0, 0, 0, 0);
        end
    for (int i = 0; i < LT; i++) step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=0 exp=1");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_base[i] = 0; m_bound[i] = 0; m_perm[i] = 0; end
    for (int i = 0; i < LT; i++) begin h_v[i] = 0; h_g[i] = 0; h_f[i] = 0; h_t[i] = ""; end
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(rsp_valid === 1'b0, "R1", "reset valid", int'(rsp_valid), 0);
    check(rsp_grant === 1'b0, "R1", "reset grant", int'(rsp_grant), 0);
    phase = "R1";
    step(1, 8'h00, 0, 0);
    step(1, 8'h40, 1, 1);
    step(1, 8'hC0, 2, 2);
    step(1, 8'hFF, 0, 0);
    for (int i = 0; i < LT; i++) step(0, 0, 0, 0);

    // R9: write takes effect only for later requests
    phase = "R9";
    cfg_we = 1; cfg_sel = 3'd2; cfg_base = 8'h40; cfg_bound = 9'h080; cfg_perm = 3'b011;
    step(1, 8'h50, 0, 0);
    cfg_we = 0;
    m_base[2] = 8'h40; m_bound[2] = 9'h080; m_perm[2] = 3'b011;
    step(1, 8'h50, 0, 0);
    for (int i = 0; i < LT; i++) step(0, 0, 0, 0);
    phase = "";

    setup(1, 0, 8'h00, 9'h040, 3'b100, 0, 0);
    setup(1, 1, 8'hC0, 9'h100, 3'b011, 0, 0);
    setup(1, 3, 8'h80, 9'h090, 3'b001, 0, 0);
    setup(1, 4, 8'h88, 9'h0A0, 3'b010, 0, 0);
    setup(1, 5, 8'hA0, 9'h0B0, 3'b111, 0, 0);
    setup(1, 6, 8'h30, 9'h050, 3'b111, 0, 0);
    sweep();

    phase = "R10";
    setup(0, 0, 0, 0, 0, 1, 9'h0E0);
    sweep();
    setup(0, 0, 0, 0, 0, 1, 9'h0F0);
    sweep();

    phase = "R9";
    setup(1, 7, 8'h00, 9'h100, 3'b111, 0, 0);
    sweep();

    phase = "R11";
    setup(1, 1, 8'hC0, 9'h0D0, 3'b011, 1, 9'h0C8);
    sweep();

    done = 1;
    finish_run();
  end

endmodule